// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

This block takes up to 32 peripheral interrupt request lines and folds them onto the nine general-purpose priority levels (7 through 15) of a core event controller. Every source owns a 4-bit level field, a mask bit and a status bit. Software reads and writes them through a flat 32-bit register interface. The block drives a 9-bit request vector. Bit k of that vector is the OR of every enabled, active source whose field selects level 7+k.

Level fields are packed eight per 32-bit assignment register. A field holds an offset from level 7. Any field value that points past level 15 parks its source on no level. After reset the assignment registers hold a fixed default map. Every source stays masked until software opens it, and the map can be rewritten at any time.

Top module: `intr_router`

## Requirements
- R1: After reset, the mask register reads 0 and `level_req_o` is 0. The assignment registers read 0x0000_0000 (address 0), 0x1100_0000 (address 1), 0x0000_0002 (address 2) and 0x0000_0000 (address 3). So sources 14 and 15 go to level 8, source 16 goes to level 9, and every other source goes to level 7.
- R2: Source n uses bits [4*(n%8)+3 : 4*(n%8)] of the assignment register at address n/8. A field value f in 0..8 selects level f+7, which is driven on `level_req_o[f]`.
- R3: A field value from 9 to 15 routes its source to no level.
- R4: When a source's mask bit is 1 (mask register, address 4, bit n), that source can drive its level. When the bit is 0, the source drives no level.
- R5: `level_req_o` is registered. After a clock edge it shows the OR over all sources of (request AND mask AND selected level), using the request levels present just before that edge.
- R6: A write to a mask or assignment register at one edge does not affect the request computed at that same edge. It does affect the request computed at the next edge.
- R7: The status register (address 5) shows the raw `irq_i` levels whatever the mask is, and writes to it change nothing.
- R8: Addresses 6 and 7 read as 0, and writes to them change nothing.
- R9: Values written to addresses 0 to 4 read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Peripheral request levels, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| level_req_o | output | 9 | Registered requests to levels 7..15 (bit 0 = level 7) |

## Verification
A configuration write and a change in request activity can land on the same clock edge. The bench provokes this in two ways. First, it raises a source while clearing its mask bit in the same cycle. Second, it raises a source while moving its level field in the same cycle. The first registered output must follow the old configuration with the new request pattern. The output one edge later must follow the new configuration. Both are compared with a bench-side model of the routing rule.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;

    localparam int FIELD_W = 4;

    // Reset-time level offset for one source
    function automatic logic [FIELD_W-1:0] default_field(input int src);
        if (src == 14 || src == 15) return FIELD_W'(1);
        if (src == 16)              return FIELD_W'(2);
        return '0;
    endfunction

endpackage

// File: rtl/intr_cfg_regs.sv
module intr_cfg_regs
    import intr_router_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    output logic [NUM_SRC*FIELD_W-1:0] asg_o,
    output logic [NUM_SRC-1:0]         mask_o
);
    localparam int SRC_PER_REG  = DATA_W / FIELD_W;
    localparam int NUM_ASG_REGS = NUM_SRC / SRC_PER_REG;
    localparam logic [ADDR_W-1:0] MASK_ADDR   = ADDR_W'(NUM_ASG_REGS);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_ASG_REGS + 1);

    typedef struct packed {
        logic [NUM_SRC*FIELD_W-1:0] asg;
        logic [NUM_SRC-1:0]         mask;
    } cfg_t;

    function automatic logic [NUM_SRC*FIELD_W-1:0] asg_reset_val();
        logic [NUM_SRC*FIELD_W-1:0] v;
        v = '0;
        for (int s = 0; s < NUM_SRC; s++) v[s*FIELD_W +: FIELD_W] = default_field(s);
        return v;
    endfunction

    localparam logic [NUM_SRC*FIELD_W-1:0] ASG_RST = asg_reset_val();

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            for (int r = 0; r < NUM_ASG_REGS; r++) begin
                if (wr_addr_i == ADDR_W'(r)) cfg_d.asg[r*DATA_W +: DATA_W] = wr_data_i;
            end
            if (wr_addr_i == MASK_ADDR) cfg_d.mask = wr_data_i[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.asg  <= ASG_RST;
            cfg_q.mask <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign asg_o  = cfg_q.asg;
    assign mask_o = cfg_q.mask;

    // R6
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> ($stable(cfg_q.asg) && $stable(cfg_q.mask)));

    // R7
    status_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == STATUS_ADDR) |=> ($stable(cfg_q.asg) && $stable(cfg_q.mask)));

endmodule

// File: rtl/intr_level_route.sv
module intr_level_route
    import intr_router_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 9
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_SRC-1:0]         irq_i,
    input  logic [NUM_SRC-1:0]         mask_i,
    input  logic [NUM_SRC*FIELD_W-1:0] asg_i,
    output logic [NUM_LVL-1:0]         req_o
);
    typedef struct packed {
        logic [NUM_LVL-1:0] req;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_SRC-1:0] live;

    assign live = irq_i & mask_i;

    always_comb begin
        st_d = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (live[s] && int'(asg_i[s*FIELD_W +: FIELD_W]) == l) st_d.req[l] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign req_o = st_q.req;

    // R4
    req_needs_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|st_d.req) |=> $past(|live));

    // R3
    one_level_per_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(st_q.req) <= $countones($past(live)));

endmodule

// File: rtl/intr_read_mux.sv
module intr_read_mux
    import intr_router_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic [ADDR_W-1:0]          rd_addr_i,
    input  logic [NUM_SRC*FIELD_W-1:0] asg_i,
    input  logic [NUM_SRC-1:0]         mask_i,
    input  logic [NUM_SRC-1:0]         irq_i,
    output logic [DATA_W-1:0]          rd_data_o
);
    localparam int SRC_PER_REG  = DATA_W / FIELD_W;
    localparam int NUM_ASG_REGS = NUM_SRC / SRC_PER_REG;
    localparam logic [ADDR_W-1:0] MASK_ADDR   = ADDR_W'(NUM_ASG_REGS);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_ASG_REGS + 1);

    always_comb begin
        rd_data_o = '0;
        for (int r = 0; r < NUM_ASG_REGS; r++) begin
            if (rd_addr_i == ADDR_W'(r)) rd_data_o = asg_i[r*DATA_W +: DATA_W];
        end
        if (rd_addr_i == MASK_ADDR)   rd_data_o = DATA_W'(mask_i);
        if (rd_addr_i == STATUS_ADDR) rd_data_o = DATA_W'(irq_i);
    end

endmodule

// File: rtl/intr_router.sv
module intr_router
    import intr_router_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 9,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [NUM_LVL-1:0] level_req_o
);
    logic [NUM_SRC*FIELD_W-1:0] asg;
    logic [NUM_SRC-1:0]         mask;

    intr_cfg_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .asg_o     (asg),
        .mask_o    (mask)
    );

    intr_level_route #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) i_route (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .irq_i  (irq_i),
        .mask_i (mask),
        .asg_i  (asg),
        .req_o  (level_req_o)
    );

    intr_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd (
        .rd_addr_i (rd_addr_i),
        .asg_i     (asg),
        .mask_i    (mask),
        .irq_i     (irq_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: tb/test_intr_router.sv
`timescale 1ns/1ps
module test_intr_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [8:0]  level_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_asg [4];
    logic [31:0] m_mask;

    always #2 clk = ~clk;

    intr_router i_intr_router (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .level_req_o(level_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [8:0] model(input logic [31:0] v);
        logic [8:0] r = '0;
        for (int s = 0; s < 32; s++) begin
            logic [3:0] f = m_asg[s/8][4*(s%8) +: 4];
            if (v[s] && m_mask[s] && f <= 4'd8) r[f] = 1'b1;
        end
        return r;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (a < 3'd4) m_asg[a] = d;
        else if (a == 3'd4) m_mask = d;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a; #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic apply(input string tag, input logic [31:0] v);
        @(negedge clk);
        irq = v;
        @(posedge clk); #1;
        chk(tag, 32'(level_req), 32'(model(v)));
    endtask

    task automatic t_reset();
        rd_chk("R1 asg0", 3'd0, 32'h0000_0000);
        rd_chk("R1 asg1", 3'd1, 32'h1100_0000);
        rd_chk("R1 asg2", 3'd2, 32'h0000_0002);
        rd_chk("R1 asg3", 3'd3, 32'h0000_0000);
        rd_chk("R1 mask", 3'd4, 32'h0);
        chk("R1 level_req", 32'(level_req), 32'h0);
    endtask

    task automatic t_mask_block();
        apply("R4 all masked", 32'hFFFF_FFFF);
        chk("R4 no request", 32'(level_req), 32'h0);
        rd_chk("R7 status raw while masked", 3'd5, 32'hFFFF_FFFF);
    endtask

    task automatic t_default_route();
        wr(3'd4, 32'hFFFF_FFFF);
        apply("R2 src0 level7", 32'h0000_0001);
        chk("R2 src0 bit0", 32'(level_req), 32'h001);
        apply("R2 src14 level8", 32'h0000_4000);
        chk("R2 src14 bit1", 32'(level_req), 32'h002);
        apply("R2 src16 level9", 32'h0001_0000);
        apply("R5 OR of src5 and src15", 32'h0000_8020);
        chk("R5 OR value", 32'(level_req), 32'h003);
        apply("R5 idle", 32'h0);
    endtask

    task automatic t_program();
        wr(3'd3, 32'hC740_F938);
        rd_chk("R9 asg3 readback", 3'd3, 32'hC740_F938);
        apply("R2 src24 level15", 32'h0100_0000);
        chk("R2 src24 bit8", 32'(level_req), 32'h100);
        apply("R3 src26 field9", 32'h0400_0000);
        chk("R3 field9 none", 32'(level_req), 32'h0);
        apply("R3 src27 field15", 32'h0800_0000);
        apply("R3 src31 field12", 32'h8000_0000);
        apply("R2 src25 and src29", 32'h2200_0000);
        chk("R2 src25/29 bits", 32'(level_req), 32'h018);
        wr(3'd0, 32'h0000_8000);
        rd_chk("R9 asg0 readback", 3'd0, 32'h0000_8000);
        apply("R2 src3 field8", 32'h0000_0008);
        chk("R2 src3 bit8", 32'(level_req), 32'h100);
        apply("R5 idle", 32'h0);
    endtask

    task automatic t_same_cycle();
        // irq rises while the mask closes, both at the same edge
        @(negedge clk);
        irq = 32'h0000_0001;
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h0;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R6 old mask at write edge", 32'(level_req), 32'h001);
        m_mask = 32'h0;
        @(posedge clk); #1;
        chk("R6 new mask next edge", 32'(level_req), 32'h0);
        wr(3'd4, 32'hFFFF_FFFF);
        // src1 rises while its field moves from 0 to 5
        @(negedge clk);
        irq = 32'h0000_0002;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0000_8050;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R6 old field at write edge", 32'(level_req), 32'h001);
        m_asg[0] = 32'h0000_8050;
        @(posedge clk); #1;
        chk("R6 new field next edge", 32'(level_req), 32'h020);
        // single-cycle pulse on src16
        @(negedge clk);
        irq = 32'h0001_0000;
        @(negedge clk);
        irq = 32'h0;
        #1 chk("R5 pulse registered", 32'(level_req), 32'h004);
        @(posedge clk); #1;
        chk("R5 pulse gone", 32'(level_req), 32'h0);
    endtask

    task automatic t_status_map();
        irq = 32'hA5A5_5A5A;
        wr(3'd5, 32'h0);
        rd_chk("R7 status shows irq", 3'd5, 32'hA5A5_5A5A);
        rd_chk("R7 mask untouched", 3'd4, 32'hFFFF_FFFF);
        wr(3'd6, 32'hDEAD_BEEF);
        wr(3'd7, 32'h1234_5678);
        rd_chk("R8 addr6 zero", 3'd6, 32'h0);
        rd_chk("R8 addr7 zero", 3'd7, 32'h0);
        rd_chk("R8 asg0 untouched", 3'd0, 32'h0000_8050);
        rd_chk("R8 asg3 untouched", 3'd3, 32'hC740_F938);
        chk("R7 routing after status write", 32'(level_req), 32'(model(irq)));
        wr(3'd4, 32'h0F0F_00FF);
        rd_chk("R9 mask readback", 3'd4, 32'h0F0F_00FF);
        apply("R4 partial mask", 32'hFFFF_FFFF);
    endtask

    initial begin
        m_asg[0] = 32'h0; m_asg[1] = 32'h1100_0000; m_asg[2] = 32'h2; m_asg[3] = 32'h0;
        m_mask = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_mask_block();
        t_default_route();
        t_program();
        t_same_cycle();
        t_status_map();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule